// File: doc/BRIEF.md
# Two-Wire Bus Start/Stop Condition Monitor

This block observes the clock and data lines of an open-drain two-wire serial bus from inside a faster system clock domain. Both lines are brought in through multi-flop synchronisers. The block then compares each synchronised sample with the previous one. It reports the framing conditions: a start, a repeated start, a stop, and each rising edge of the bus clock, which a byte engine downstream can use to sample bits. It does not drive the lines and it does not decode bytes.

The block also keeps a busy level. A start condition sets it. It clears after a guard interval that follows a stop. It also clears when both lines have stayed high for longer than a programmable count of system cycles. With this timeout a master can claim a bus that another agent left busy without ever sending a stop. Both intervals are parameters counted in system clock cycles. For example, 2500 cycles at 50 MHz gives a 50 µs idle timeout.

Top module: `bus_cond_mon`

## Requirements
- R1: While rst_ni is low and right after it is released, busy_o, start_o, stop_o, restart_o and scl_rise_o are all 0. The synchronisers reset to the idle level, with both lines high.
- R2: A falling data line while the clock line is high produces exactly one start_o pulse, one cycle wide. It appears in the cycle after the SYNC_STAGES-th rising edge at which the changed input was first sampled.
- R3: A rising data line while the clock line is high produces exactly one stop_o pulse, one cycle wide, with the same latency as R2.
- R4: busy_o is 1 from the cycle after a start_o pulse.
- R5: After a stop_o pulse while busy, busy_o stays 1 for exactly GUARD_CYCLES further cycles and then drops to 0, unless R6 or R10 applies first.
- R6: When both synchronised lines have been high for IDLE_CYCLES consecutive cycles, busy_o drops to 0 on the next cycle, even if no stop was seen. Any low sample on either line restarts this count.
- R7: scl_rise_o pulses for one cycle for each low-to-high change of the synchronised clock line, with the same latency as R2.
- R8: A start seen while busy_o is 1 also raises restart_o in the same cycle as start_o, and busy_o stays 1.
- R9: A change on the data line while the clock line is low produces no start_o and no stop_o pulse. start_o and stop_o are never high together.
- R10: A start that arrives during the guard interval of R5 cancels that interval, and busy_o stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed (asynchronous) |
| sda_i | input | 1 | Bus data line as sensed (asynchronous) |
| start_o | output | 1 | One-cycle pulse on a start condition |
| stop_o | output | 1 | One-cycle pulse on a stop condition |
| restart_o | output | 1 | One-cycle pulse on a start seen while busy |
| scl_rise_o | output | 1 | One-cycle pulse on a rising bus clock |
| busy_o | output | 1 | Bus busy level |

## Verification
The bench builds the block with IDLE_CYCLES = 40 and GUARD_CYCLES = 6 and keeps the default two synchroniser stages. With these values the guard expiry, a start that lands inside the guard window, and the both-lines-high timeout all fall within a few dozen cycles. This lets one short run reach every busy-clearing path and the cancellation of the guard. The short guard, set well below the timeout, also keeps the two clearing paths apart, so the bench can tell which one acted.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  typedef struct packed {
    logic scl;
    logic sda;
  } bcm_lines_t;

  localparam bcm_lines_t LINES_IDLE = '{scl: 1'b1, sda: 1'b1};
endpackage

// File: rtl/bcm_sync.sv
module bcm_sync
  import bcm_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  bcm_lines_t lines_i,
  output bcm_lines_t lines_o
);
  bcm_lines_t stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= LINES_IDLE;
        else         stage_q[i] <= lines_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= LINES_IDLE;
        else         stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign lines_o = stage_q[STAGES-1];
endmodule

// File: rtl/bcm_cond_det.sv
module bcm_cond_det
  import bcm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  bcm_lines_t lines_s_i,
  output logic       start_o,
  output logic       stop_o,
  output logic       scl_rise_o
);
  bcm_lines_t prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= LINES_IDLE;
    else         prev_q <= lines_s_i;
  end

  // clock high across both samples qualifies a data edge as a condition
  logic scl_held;
  assign scl_held   = prev_q.scl & lines_s_i.scl;
  assign start_o    = scl_held &  prev_q.sda & ~lines_s_i.sda;
  assign stop_o     = scl_held & ~prev_q.sda &  lines_s_i.sda;
  assign scl_rise_o = ~prev_q.scl & lines_s_i.scl;

  a_r2_start_single : assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  a_r3_stop_single : assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);
  a_r9_cond_exclusive : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));
  a_r7_rise_single : assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rise_o |=> !scl_rise_o);
endmodule

// File: rtl/bcm_busy_tracker.sv
module bcm_busy_tracker
  import bcm_pkg::*;
#(
  parameter int IDLE_CYCLES  = 2500,
  parameter int GUARD_CYCLES = 250
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  bcm_lines_t lines_s_i,
  input  logic       start_i,
  input  logic       stop_i,
  output logic       busy_o
);
  localparam int HW = $clog2(IDLE_CYCLES + 1);
  localparam int GW = (GUARD_CYCLES > 1) ? $clog2(GUARD_CYCLES) : 1;
  localparam logic [HW-1:0] HI_LIMIT   = HW'(IDLE_CYCLES);
  localparam logic [GW-1:0] GUARD_LAST = GW'(GUARD_CYCLES - 1);

  logic [HW-1:0] hi_cnt_q;
  logic [GW-1:0] guard_cnt_q;
  logic          guard_act_q;
  logic          busy_q;
  logic          both_hi, timeout, guard_last;

  assign both_hi    = lines_s_i.scl & lines_s_i.sda;
  assign timeout    = (hi_cnt_q >= HI_LIMIT);
  assign guard_last = (guard_cnt_q == GUARD_LAST);

  // saturating run length of both-lines-high samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_cnt_q <= '0;
    else if (!both_hi) hi_cnt_q <= '0;
    else if (!timeout) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      guard_act_q <= 1'b0;
      guard_cnt_q <= '0;
    end else if (start_i) begin
      busy_q      <= 1'b1;
      guard_act_q <= 1'b0;
    end else if (timeout) begin
      busy_q      <= 1'b0;
      guard_act_q <= 1'b0;
    end else if (guard_act_q) begin
      if (guard_last) begin
        busy_q      <= 1'b0;
        guard_act_q <= 1'b0;
      end else begin
        guard_cnt_q <= guard_cnt_q + 1'b1;
      end
    end else if (stop_i && busy_q) begin
      guard_act_q <= 1'b1;
      guard_cnt_q <= '0;
    end
  end

  assign busy_o = busy_q;

  a_r4_busy_after_start : assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  a_r6_timeout_clears : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout && !start_i) |=> !busy_o);
  a_r5_guard_holds : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (guard_act_q && !guard_last && !timeout) |=> busy_o);
  a_r6_count_bound : assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_cnt_q <= HI_LIMIT);
  a_r10_guard_needs_busy : assert property (@(posedge clk_i) disable iff (!rst_ni)
    guard_act_q |-> busy_o);
endmodule

// File: rtl/bus_cond_mon.sv
module bus_cond_mon
  import bcm_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int IDLE_CYCLES  = 2500,
  parameter int GUARD_CYCLES = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic restart_o,
  output logic scl_rise_o,
  output logic busy_o
);
  bcm_lines_t lines_raw, lines_s;
  logic       start_w, stop_w, rise_w, busy_w;

  assign lines_raw = '{scl: scl_i, sda: sda_i};

  bcm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i (lines_raw),
    .lines_o (lines_s)
  );

  bcm_cond_det u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lines_s_i  (lines_s),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .scl_rise_o (rise_w)
  );

  bcm_busy_tracker #(
    .IDLE_CYCLES  (IDLE_CYCLES),
    .GUARD_CYCLES (GUARD_CYCLES)
  ) u_busy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lines_s_i (lines_s),
    .start_i   (start_w),
    .stop_i    (stop_w),
    .busy_o    (busy_w)
  );

  assign start_o    = start_w;
  assign stop_o     = stop_w;
  assign scl_rise_o = rise_w;
  assign busy_o     = busy_w;
  assign restart_o  = start_w & busy_w;

  a_r8_restart_keeps_busy : assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> busy_o);
endmodule

// File: tb/bus_cond_mon_bench.sv
module bus_cond_mon_bench;
  localparam int SYNC  = 2;
  localparam int IDLE  = 40;
  localparam int GUARD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1;
  logic start_o, stop_o, restart_o, scl_rise_o, busy_o;

  always #10 clk = ~clk;

  bus_cond_mon #(.SYNC_STAGES(SYNC), .IDLE_CYCLES(IDLE), .GUARD_CYCLES(GUARD)) u_bus_cond_mon (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .start_o(start_o), .stop_o(stop_o), .restart_o(restart_o),
    .scl_rise_o(scl_rise_o), .busy_o(busy_o)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;

  // behavioural reference
  logic qscl[$], qsda[$];
  bit   m_busy, m_gact;
  int   m_gcnt, m_hi;
  int   n_start, n_stop, n_rise, n_rs, busy_after_stop;

  function automatic bit m_start();
    return qscl[0] && qscl[1] && qsda[0] && !qsda[1];
  endfunction
  function automatic bit m_stop();
    return qscl[0] && qscl[1] && !qsda[0] && qsda[1];
  endfunction
  function automatic bit m_rise();
    return !qscl[0] && qscl[1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qscl.delete(); qsda.delete();
      for (int i = 0; i <= SYNC; i++) begin qscl.push_back(1'b1); qsda.push_back(1'b1); end
      m_busy = 0; m_gact = 0; m_gcnt = 0; m_hi = 0;
      n_start = 0; n_stop = 0; n_rise = 0; n_rs = 0; busy_after_stop = 0;
    end else begin
      bit st, sp;
      st = m_start(); sp = m_stop();
      n_start += int'(start_o); n_stop += int'(stop_o);
      n_rise += int'(scl_rise_o); n_rs += int'(restart_o);
      if (stop_o) busy_after_stop = 0;
      else if (busy_o) busy_after_stop++;
      if (st) begin m_busy = 1; m_gact = 0; end
      else if (m_hi >= IDLE) begin m_busy = 0; m_gact = 0; end
      else if (m_gact) begin
        if (m_gcnt == GUARD - 1) begin m_busy = 0; m_gact = 0; end
        else m_gcnt++;
      end else if (sp && m_busy) begin m_gact = 1; m_gcnt = 0; end
      if (qscl[1] && qsda[1]) m_hi = (m_hi < IDLE) ? m_hi + 1 : IDLE;
      else m_hi = 0;
      qscl.push_back(scl_i); qsda.push_back(sda_i);
      void'(qscl.pop_front()); void'(qsda.pop_front());
    end
  end

  task automatic cmp(string tag, logic got, logic exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %0b expected %0b at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  task automatic chk_int(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R2 start_o",    start_o,    m_start());
      cmp("R3 stop_o",     stop_o,     m_stop());
      cmp("R7 scl_rise_o", scl_rise_o, m_rise());
      cmp("R8 restart_o",  restart_o,  m_start() && m_busy);
      cmp("R4 busy_o",     busy_o,     m_busy);
    end
  end

  task automatic summary();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic hold(logic c, logic d, int n);
    @(negedge clk);
    scl_i = c; sda_i = d;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    int rise0;
    logic [8:0] bits;
    repeat (3) @(negedge clk);
    cmp("R1 busy_o in reset", busy_o, 1'b0);
    cmp("R1 start_o in reset", start_o, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R1 busy_o after reset", busy_o, 1'b0);
    cmp("R1 stop_o after reset", stop_o, 1'b0);

    // data toggles with clock low while idle
    hold(1'b0, 1'b1, 4); hold(1'b0, 1'b0, 4); hold(1'b0, 1'b1, 4); hold(1'b1, 1'b1, 6);
    chk_int("R9 no start on low-clock toggles", n_start, 0);
    chk_int("R9 no stop on low-clock toggles", n_stop, 0);

    // start then nine clocked bits
    hold(1'b1, 1'b0, 4);
    hold(1'b0, 1'b0, 3);
    rise0 = n_rise;
    bits = 9'b1010_0101_0;
    for (int i = 8; i >= 0; i--) begin
      hold(1'b0, bits[i], 3);
      hold(1'b1, bits[i], 3);
    end
    hold(1'b1, 1'b0, 4);
    chk_int("R2 one start", n_start, 1);
    chk_int("R9 no stop during bits", n_stop, 0);
    chk_int("R7 nine clock rises", n_rise - rise0, 9);
    cmp("R4 busy after start", busy_o, 1'b1);

    // repeated start
    hold(1'b0, 1'b0, 3); hold(1'b0, 1'b1, 3); hold(1'b1, 1'b1, 3); hold(1'b1, 1'b0, 4);
    chk_int("R8 one repeated start", n_rs, 1);
    cmp("R8 busy kept", busy_o, 1'b1);

    // stop and guard expiry
    hold(1'b0, 1'b0, 3); hold(1'b1, 1'b0, 3); hold(1'b1, 1'b1, GUARD + 8);
    chk_int("R3 one stop", n_stop, 1);
    chk_int("R5 busy cycles after stop", busy_after_stop, GUARD);
    cmp("R5 idle after guard", busy_o, 1'b0);

    // start within guard
    hold(1'b1, 1'b0, 3); hold(1'b0, 1'b0, 3); hold(1'b1, 1'b0, 3);
    hold(1'b1, 1'b1, 2); hold(1'b1, 1'b0, 3);
    hold(1'b0, 1'b0, GUARD + 10);
    cmp("R10 busy held after start in guard", busy_o, 1'b1);

    // both lines high without stop
    hold(1'b0, 1'b1, 3);
    hold(1'b1, 1'b1, IDLE / 2);
    cmp("R6 busy before timeout", busy_o, 1'b1);
    repeat (IDLE) @(negedge clk);
    cmp("R6 idle after timeout", busy_o, 1'b0);
    chk_int("R6 no stop used", n_stop, 2);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule